// File: doc/BRIEF.md
# Analog Input Scan Sequencer

This block sits behind a byte-wide register bus and drives an external analog-to-digital converter through a multiplexer. The host programs a first and a last channel number, a range and settling code, and a few control bits. A write to the start address then runs either one conversion on the first channel or, in scan mode, a sweep over every channel from first to last. Each sample goes into a sample FIFO, and the host reads it out as a low byte and a high byte.

The converter is reached through a request/acknowledge port. The block holds `cnv_req` high with a stable channel on `mux_chan` until the converter pulses `cnv_ack` with the 16-bit two's complement result on `cnv_data`. After any write to a channel register or to the range register, a settle timer runs. No request is issued while it runs. The timer's length in clock cycles is `SETTLE_UNIT` times 4, 3, 2 or 1, selected by the interval field of the range register. An optional interrupt marks the end of each conversion run. A write to the control register acknowledges the interrupt or returns the whole block to its reset state.

Register offsets: 0 = start (write) / sample low byte (read); 1 = sample high byte (read, removes the sample); 2 = first channel; 3 = last channel; 7 = FIFO control (write) / FIFO status (read); 8 = control (write) / status (read); 9 = interrupt and timing; 11 = range/settling code (write) / readback with settle flag (read). Any other offset reads 0x00.

Top module: `ai_scan_seq`

## Requirements
- R1: After reset these reads hold: offset 8 reads 0x60, offset 7 reads 0x80, offset 11 reads 0x0C, offset 9 reads 0x00, offsets 2 and 3 read 0x00, and `irq` is low.
- R2: The channel registers at offsets 2 and 3 keep only bits 4:0 and read back zero-extended. Writing 0x80 reads back 0x00, and writing 0xFF reads back 0x1F.
- R3: Offset 11 reads back the stored code in bits 5:0, with bit 7 as the settle flag. Bit 7 is high for exactly SETTLE_UNIT*(4-s) clock cycles after any write to offset 2, 3 or 11. Here s is bits 5:4 of the code in force; on a write to offset 11 that is the value just written.
- R4: With scan mode off, a write to offset 0 converts only the first channel and places exactly one sample in the FIFO.
- R5: With scan mode on (bit 2 of a write to offset 7), one start converts every channel from first to last inclusive. The samples enter the FIFO in ascending channel order.
- R6: In scan mode, if the last channel is below the first, only the first channel is converted.
- R7: A read of offset 0 returns bits 7:0 of the oldest sample, and offset 1 returns bits 15:8. A read strobe at offset 1 removes that sample. An empty FIFO reads 0x00 at both offsets. Offset 7 bit 7 flags the FIFO as empty, and bit 6 flags it as full.
- R8: Offset 8 bit 7 is high from the cycle after a start until the last sample of the run is stored. A start written while this bit is high is ignored.
- R9: `cnv_req` stays high with `mux_chan` unchanged until `cnv_ack` arrives. No request begins while the settle flag is high.
- R10: When bit 7 of offset 9 has been written as 1, the end of a run sets a pending flag. The flag drives `irq` and reads back as offset 9 bit 7. It is not set before the last sample, and it stays set until a write to offset 8 with bit 3 set. With the enable clear, no flag is raised.
- R11: A write to offset 7 with bit 1 set empties the FIFO.
- R12: A write to offset 8 with bit 5 set returns every register, the FIFO, the settle timer and the sequencer to the R1 state.
- R13: Bits 1:0 written to offset 9 (the scan start source select) read back in bits 1:0 of offset 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; at offset 1 it removes the oldest sample |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mux_chan | output | 5 | Channel presented to the multiplexer |
| cnv_req | output | 1 | Conversion request |
| cnv_ack | input | 1 | Conversion done, one-cycle pulse |
| cnv_data | input | 16 | Conversion result, valid with `cnv_ack` |
| irq | output | 1 | Pending end-of-run interrupt |

## Verification
Runs are started in four patterns: a single conversion with scan mode off, an ascending scan of several channels, a scan whose last channel is below its first, and a second start issued while a scan is already running. Each sample carries its channel number in its upper bits. Because of this, the order of drained samples and the count before the FIFO reports empty tell apart a wrong step direction, a missed endpoint, an extra conversion and a start that was wrongly accepted. The settle flag is timed at two interval codes, which catches a wrong multiplier and a stale interval code. A start issued while the flag is high checks that the request waits.

// File: rtl/ais_pkg.sv
package ais_pkg;
    // register offsets (the host software decodes these)
    localparam logic [3:0] OFS_DATA_LO = 4'h0;
    localparam logic [3:0] OFS_DATA_HI = 4'h1;
    localparam logic [3:0] OFS_CHAN_LO = 4'h2;
    localparam logic [3:0] OFS_CHAN_HI = 4'h3;
    localparam logic [3:0] OFS_FIFO    = 4'h7;
    localparam logic [3:0] OFS_CTRL    = 4'h8;
    localparam logic [3:0] OFS_TIMING  = 4'h9;
    localparam logic [3:0] OFS_CFG     = 4'hB;

    // bit positions inside written bytes
    localparam int FCTL_CLEAR_BIT = 1;
    localparam int FCTL_SCAN_BIT  = 2;
    localparam int CTRL_ACK_BIT   = 3;
    localparam int CTRL_RST_BIT   = 5;
    localparam int TMG_IEN_BIT    = 7;

    localparam logic [5:0] CFG_RESET    = 6'h0C;
    localparam logic [7:0] STATUS_FIXED = 8'h60;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SETTLE,
        SEQ_CONVERT
    } seq_state_e;

    // settling length: interval code 0..3 maps to 4..1 units
    function automatic int unsigned settle_cycles(input logic [1:0] sel,
                                                  input int unsigned unit);
        return unit * (32'd4 - 32'(sel));
    endfunction
endpackage

// File: rtl/ais_settle_timer.sv
module ais_settle_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/ais_sample_fifo.sv
module ais_sample_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W:0]    count;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == (PTR_W+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/ais_sequencer.sv
module ais_sequencer
    import ais_pkg::*;
#(
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              start,
    input  logic              scan_en,
    input  logic [CHAN_W-1:0] chan_lo,
    input  logic [CHAN_W-1:0] chan_hi,
    input  logic              settle_busy,
    input  logic              cnv_ack,
    output logic              cnv_req,
    output logic [CHAN_W-1:0] mux_chan,
    output logic              push,
    output logic              done,
    output logic              busy
);
    seq_state_e        state_q;
    logic [CHAN_W-1:0] cur_q, end_q;
    logic              at_end;

    assign at_end   = (cur_q >= end_q);
    assign cnv_req  = (state_q == SEQ_CONVERT);
    assign push     = cnv_req && cnv_ack;
    assign done     = push && at_end;
    assign busy     = (state_q != SEQ_IDLE);
    assign mux_chan = cur_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            end_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    cur_q   <= chan_lo;
                    end_q   <= scan_en ? chan_hi : chan_lo;
                    state_q <= SEQ_SETTLE;
                end
                SEQ_SETTLE: if (!settle_busy)
                    state_q <= SEQ_CONVERT;
                SEQ_CONVERT: if (cnv_ack) begin
                    if (at_end) state_q <= SEQ_IDLE;
                    else        cur_q   <= cur_q + 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ai_scan_seq.sv
module ai_scan_seq
    import ais_pkg::*;
#(
    parameter int CHAN_W      = 5,
    parameter int SAMPLE_W    = 16,
    parameter int FIFO_DEPTH  = 32,
    parameter int SETTLE_UNIT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic [CHAN_W-1:0]   mux_chan,
    output logic                cnv_req,
    input  logic                cnv_ack,
    input  logic [SAMPLE_W-1:0] cnv_data,
    output logic                irq
);
    localparam int SETTLE_MAX = SETTLE_UNIT * 4;
    localparam int CNT_W      = $clog2(SETTLE_MAX + 1);

    logic [CHAN_W-1:0]   chan_lo_q, chan_hi_q;
    logic [5:0]          cfg_q;
    logic [1:0]          clk_sel_q;
    logic                scan_en_q, int_en_q, irq_q;
    logic                wr_start, wr_lo, wr_hi, wr_fifo, wr_ctrl, wr_tmg, wr_cfg;
    logic                soft_rst, fifo_clr, irq_ack, settle_load;
    logic [1:0]          settle_sel;
    logic [CNT_W-1:0]    settle_len;
    logic                settle_busy, seq_busy, seq_push, seq_done;
    logic                fifo_empty, fifo_full, fifo_pop;
    logic [SAMPLE_W-1:0] fifo_rdata;

    assign wr_start = bus_wr && (bus_addr == OFS_DATA_LO);
    assign wr_lo    = bus_wr && (bus_addr == OFS_CHAN_LO);
    assign wr_hi    = bus_wr && (bus_addr == OFS_CHAN_HI);
    assign wr_fifo  = bus_wr && (bus_addr == OFS_FIFO);
    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_tmg   = bus_wr && (bus_addr == OFS_TIMING);
    assign wr_cfg   = bus_wr && (bus_addr == OFS_CFG);

    assign soft_rst    = wr_ctrl && bus_wdata[CTRL_RST_BIT];
    assign irq_ack     = wr_ctrl && bus_wdata[CTRL_ACK_BIT];
    assign fifo_clr    = soft_rst || (wr_fifo && bus_wdata[FCTL_CLEAR_BIT]);
    assign fifo_pop    = bus_rd && (bus_addr == OFS_DATA_HI);
    assign settle_load = wr_lo || wr_hi || wr_cfg;
    assign settle_sel  = wr_cfg ? bus_wdata[5:4] : cfg_q[5:4];
    assign settle_len  = CNT_W'(settle_cycles(settle_sel, SETTLE_UNIT));

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            chan_lo_q <= '0;
            chan_hi_q <= '0;
            cfg_q     <= CFG_RESET;
            clk_sel_q <= '0;
            scan_en_q <= 1'b0;
            int_en_q  <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (wr_lo)   chan_lo_q <= bus_wdata[CHAN_W-1:0];
            if (wr_hi)   chan_hi_q <= bus_wdata[CHAN_W-1:0];
            if (wr_cfg)  cfg_q     <= bus_wdata[5:0];
            if (wr_fifo) scan_en_q <= bus_wdata[FCTL_SCAN_BIT];
            if (wr_tmg) begin
                int_en_q  <= bus_wdata[TMG_IEN_BIT];
                clk_sel_q <= bus_wdata[1:0];
            end
            if (seq_done && int_en_q) irq_q <= 1'b1;
            else if (irq_ack)         irq_q <= 1'b0;
        end
    end

    ais_settle_timer #(.CNT_W(CNT_W)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .clr  (soft_rst),
        .load (settle_load),
        .len  (settle_len),
        .busy (settle_busy)
    );

    ais_sequencer #(.CHAN_W(CHAN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .clr         (soft_rst),
        .start       (wr_start),
        .scan_en     (scan_en_q),
        .chan_lo     (chan_lo_q),
        .chan_hi     (chan_hi_q),
        .settle_busy (settle_busy),
        .cnv_ack     (cnv_ack),
        .cnv_req     (cnv_req),
        .mux_chan    (mux_chan),
        .push        (seq_push),
        .done        (seq_done),
        .busy        (seq_busy)
    );

    ais_sample_fifo #(.DATA_W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (seq_push),
        .wdata (cnv_data),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_DATA_LO: bus_rdata = fifo_rdata[7:0];
            OFS_DATA_HI: bus_rdata = 8'(fifo_rdata >> 8);
            OFS_CHAN_LO: bus_rdata = 8'(chan_lo_q);
            OFS_CHAN_HI: bus_rdata = 8'(chan_hi_q);
            OFS_FIFO:    bus_rdata = {fifo_empty, fifo_full, 6'b0};
            OFS_CTRL:    bus_rdata = STATUS_FIXED | {seq_busy, 7'b0};
            OFS_TIMING:  bus_rdata = {irq_q, 5'b0, clk_sel_q};
            OFS_CFG:     bus_rdata = {settle_busy, 1'b0, cfg_q};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq = irq_q;
endmodule

// File: rtl/ai_scan_seq_chk.sv
module ai_scan_seq_chk #(
    parameter int CHAN_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              cnv_req,
    input logic              cnv_ack,
    input logic [CHAN_W-1:0] mux_chan,
    input logic              irq,
    input logic              settle_busy,
    input logic              fifo_empty
);
    logic soft_w, ack_w;
    assign soft_w = bus_wr && (bus_addr == 4'h8) && bus_wdata[5];
    assign ack_w  = bus_wr && (bus_addr == 4'h8) && bus_wdata[3];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        cnv_req && !cnv_ack && !soft_w |=> cnv_req && $stable(mux_chan)); // R9

    AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_req) |-> !$past(settle_busy)); // R9

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        cnv_req && cnv_ack && !soft_w |=> !cnv_req || (mux_chan == $past(mux_chan) + 1'b1)); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq && !ack_w && !soft_w |=> irq); // R10

    AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == 4'h7) && bus_wdata[1] |=> fifo_empty); // R11
endmodule

bind ai_scan_seq ai_scan_seq_chk #(.CHAN_W(CHAN_W)) u_chk (.*);

// File: tb/ai_scan_seq_test.sv
module ai_scan_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [4:0]  mux_chan;
    logic        cnv_req;
    logic        cnv_ack;
    logic [15:0] cnv_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ai_scan_seq uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mux_chan(mux_chan), .cnv_req(cnv_req), .cnv_ack(cnv_ack),
        .cnv_data(cnv_data), .irq(irq)
    );

    function automatic logic [15:0] sample_of(input logic [4:0] c);
        return {3'b101, c, 8'(c) ^ 8'h5A};
    endfunction

    // converter model: acknowledges one cycle after each request
    always @(posedge clk) begin
        if (rst) begin
            cnv_ack  <= 1'b0;
            cnv_data <= '0;
        end else begin
            cnv_ack <= cnv_req && !cnv_ack;
            if (cnv_req && !cnv_ack) cnv_data <= sample_of(mux_chan);
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pop_sample(output logic [15:0] s);
        logic [7:0] lo, hi;
        bus_read(4'h0, lo);
        bus_read(4'h1, hi);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        s = {hi, lo};
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 400; i++) begin
            bus_read(4'h8, v);
            if (!v[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_settle();
        logic [7:0] v;
        for (int i = 0; i < 100; i++) begin
            bus_read(4'hB, v);
            if (!v[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(4'h8, v); check(v == 8'h60, "R1 status", v, 8'h60);
        bus_read(4'h7, v); check(v == 8'h80, "R1 fifo status", v, 8'h80);
        bus_read(4'hB, v); check(v == 8'h0C, "R1 config", v, 8'h0C);
        bus_read(4'h9, v); check(v == 8'h00, "R1 timing", v, 8'h00);
        bus_read(4'h2, v); check(v == 8'h00, "R1 first chan", v, 8'h00);
        bus_read(4'h3, v); check(v == 8'h00, "R1 last chan", v, 8'h00);
        check(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_chan_mask();
        logic [7:0] v;
        bus_write(4'h2, 8'h80);
        bus_read(4'h2, v); check(v == 8'h00, "R2 mask 0x80", v, 8'h00);
        bus_write(4'h3, 8'hFF);
        bus_read(4'h3, v); check(v == 8'h1F, "R2 mask 0xFF", v, 8'h1F);
        wait_settle();
    endtask

    task automatic count_settle(output int n);
        logic [7:0] v;
        n = 0;
        bus_read(4'hB, v);
        while (v[7] && n < 100) begin
            n++;
            @(negedge clk);
            bus_read(4'hB, v);
        end
    endtask

    task automatic t_settle();
        logic [7:0] v;
        int n;
        bus_write(4'hB, 8'h0D);
        count_settle(n); check(n == 16, "R3 settle code0", n, 16);
        bus_read(4'hB, v); check(v == 8'h0D, "R3 readback", v, 8'h0D);
        bus_write(4'hB, 8'h3C);
        count_settle(n); check(n == 4, "R3 settle code3", n, 4);
        bus_write(4'h2, 8'h01);
        count_settle(n); check(n == 4, "R3 settle on chan write", n, 4);
        bus_read(4'hB, v); check(v == 8'h3C, "R3 readback2", v, 8'h3C);
    endtask

    task automatic t_single();
        logic [7:0]  v;
        logic [15:0] s;
        bus_write(4'h7, 8'h02);
        bus_write(4'h2, 8'h05);
        bus_write(4'h3, 8'h09);
        bus_write(4'h0, 8'hFF);
        bus_read(4'hB, v);
        check(v[7] == 1'b1 && cnv_req == 1'b0, "R9 no request while settling",
              {v[7], cnv_req}, 2'b10);
        wait_idle();
        bus_read(4'h7, v); check(v[7] == 1'b0, "R4 one sample stored", v, 8'h00);
        pop_sample(s); check(s == sample_of(5), "R4 first channel only", s, sample_of(5));
        bus_read(4'h7, v); check(v == 8'h80, "R4 single sample", v, 8'h80);
        bus_read(4'h0, v); check(v == 8'h00, "R7 empty low byte", v, 8'h00);
        bus_read(4'h1, v); check(v == 8'h00, "R7 empty high byte", v, 8'h00);
    endtask

    task automatic t_scan();
        logic [7:0]  v;
        logic [15:0] s;
        bus_write(4'h7, 8'h06);
        bus_write(4'h2, 8'h03);
        bus_write(4'h3, 8'h06);
        bus_write(4'h0, 8'hFF);
        bus_read(4'h8, v); check(v[7] == 1'b1, "R8 busy after start", v, 8'hE0);
        wait_idle();
        for (int c = 3; c <= 6; c++) begin
            pop_sample(s);
            check(s == sample_of(5'(c)), "R5 scan order", s, sample_of(5'(c)));
        end
        bus_read(4'h7, v); check(v == 8'h80, "R5 scan count", v, 8'h80);
    endtask

    task automatic t_scan_inverted();
        logic [7:0]  v;
        logic [15:0] s;
        bus_write(4'h2, 8'h0A);
        bus_write(4'h3, 8'h02);
        bus_write(4'h0, 8'hFF);
        wait_idle();
        pop_sample(s); check(s == sample_of(10), "R6 first only", s, sample_of(10));
        bus_read(4'h7, v); check(v == 8'h80, "R6 one sample", v, 8'h80);
    endtask

    task automatic t_busy_ignore();
        logic [7:0]  v;
        logic [15:0] s;
        bus_write(4'h2, 8'h00);
        bus_write(4'h3, 8'h03);
        bus_write(4'h0, 8'hFF);
        bus_write(4'h0, 8'hFF);
        wait_idle();
        for (int c = 0; c <= 3; c++) begin
            pop_sample(s);
            check(s == sample_of(5'(c)), "R8 run samples", s, sample_of(5'(c)));
        end
        bus_read(4'h7, v); check(v == 8'h80, "R8 second start ignored", v, 8'h80);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        bus_write(4'h9, 8'h80);
        bus_write(4'h2, 8'h01);
        bus_write(4'h3, 8'h04);
        bus_write(4'h0, 8'hFF);
        check(irq == 1'b0, "R10 no irq mid run", irq, 0);
        wait_idle();
        @(negedge clk);
        check(irq == 1'b1, "R10 irq at end", irq, 1);
        bus_read(4'h9, v); check(v[7] == 1'b1, "R10 pending readback", v, 8'h80);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, "R10 irq sticky", irq, 1);
        bus_write(4'h8, 8'h08);
        check(irq == 1'b0, "R10 irq ack", irq, 0);
        bus_write(4'h7, 8'h06);
        bus_write(4'h9, 8'h00);
        bus_write(4'h0, 8'hFF);
        wait_idle();
        @(negedge clk);
        check(irq == 1'b0, "R10 disabled no irq", irq, 0);
    endtask

    task automatic t_fifo_reset();
        logic [7:0] v;
        bus_read(4'h7, v); check(v[7] == 1'b0, "R11 fifo has data", v, 8'h00);
        bus_write(4'h7, 8'h06);
        bus_read(4'h7, v); check(v == 8'h80, "R11 fifo cleared", v, 8'h80);
        bus_read(4'h0, v); check(v == 8'h00, "R11 cleared data", v, 8'h00);
    endtask

    task automatic t_clksel();
        logic [7:0] v;
        bus_write(4'h9, 8'h03);
        bus_read(4'h9, v); check(v == 8'h03, "R13 clock select", v, 8'h03);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        bus_write(4'h9, 8'h82);
        bus_write(4'h2, 8'h07);
        bus_write(4'h3, 8'h09);
        bus_write(4'hB, 8'h3D);
        bus_write(4'h0, 8'hFF);
        wait_idle();
        @(negedge clk);
        check(irq == 1'b1, "R12 setup irq", irq, 1);
        bus_write(4'h8, 8'h20);
        bus_read(4'h8, v); check(v == 8'h60, "R12 status", v, 8'h60);
        bus_read(4'h7, v); check(v == 8'h80, "R12 fifo", v, 8'h80);
        bus_read(4'hB, v); check(v == 8'h0C, "R12 config", v, 8'h0C);
        bus_read(4'h9, v); check(v == 8'h00, "R12 timing", v, 8'h00);
        bus_read(4'h2, v); check(v == 8'h00, "R12 first chan", v, 8'h00);
        check(irq == 1'b0, "R12 irq", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_chan_mask();
        t_settle();
        t_single();
        t_scan();
        t_scan_inverted();
        t_busy_ignore();
        t_irq();
        t_fifo_reset();
        t_clksel();
        t_soft_reset();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule